// File: doc/BRIEF.md
# Synchronous Character Receiver with Lagging CRC Check

This block receives a synchronous serial bit stream one bit per strobe, least significant bit first, and builds eight-bit characters. Each finished character goes into a small receive queue. A copy of that character then sits in a one-character holding register while the next character arrives, and the CRC checker consumes the held character bit by bit during that time. The CRC therefore always works one character behind the queue.

Software decides, character by character, whether a character counts toward the CRC. It does this through a `crc_en` level that the block samples only when a character enters the queue. Each queue entry carries a flag that shows whether the CRC remainder was zero when the entry was written. Because of the holding register and the moment at which the flag is sampled, the flag that covers a message's last CRC byte arrives two characters after that byte.

The receiver stays quiet until it is enabled and has left hunt mode. A hunt request clears the CRC state. An optional gate driven by carrier detect can stop the receiver at once, and when it does, the character being assembled is thrown away.

Top module: `sync_rx_dcrc`

## Requirements
- R1: On each `rx_clk_en` strobe the block samples `rx_data`, least significant bit first. On the eighth bit's strobe the finished character is written to the queue. The oldest character appears on `rd_data` with `rd_valid` high in the cycle after that edge.
- R2: `hunting` is 1 after reset. Bits are ignored while `hunting` is 1 or while `rx_en` is 0. A `sync_found` pulse clears `hunting`.
- R3: A character's CRC participation is set by the value of `crc_en` at the edge where that character is written to the queue. The CRC then consumes that character, one bit per strobe, while the next character is being received.
- R4: The CRC is computed bit-serially over the polynomial x^16+x^15+x^2+1, fed least significant bit first, with a preset of 0x0000. A message followed by its CRC, sent low byte first and then high byte, leaves a remainder of zero.
- R5: At every write to the queue, the flag stored with the character is 1 exactly when the CRC register was zero before that edge's update. As a result, the zero result for a message's last CRC byte is paired with the second character after it.
- R6: The flag travels with its character and stays on `rd_crc_zero` until that character is popped.
- R7: A `hunt_req` pulse sets `hunting`. It also clears the bit counter, the holding register, the CRC register and the sampled CRC enable.
- R8: With `auto_en`=1, `dcd_n`=1 stops the receiver at once and discards the partial character, and reception restarts from bit 0 when `dcd_n` returns to 0. With `auto_en`=0, `dcd_n` has no effect.
- R9: The queue holds 3 characters. A write while it holds 3 characters, even in a cycle that also pops, is dropped and sets `overrun`, which stays 1 until reset.
- R10: A `pop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| auto_en | input | 1 | Lets `dcd_n` gate the receiver |
| dcd_n | input | 1 | Carrier detect, active low |
| hunt_req | input | 1 | Pulse: enter hunt mode and clear CRC state |
| sync_found | input | 1 | Pulse: leave hunt mode |
| rx_clk_en | input | 1 | Bit strobe, one clock wide |
| rx_data | input | 1 | Serial data bit |
| crc_en | input | 1 | CRC participation for the character being written |
| pop | input | 1 | Remove the oldest queue entry |
| rd_valid | output | 1 | Queue is not empty |
| rd_data | output | 8 | Oldest character |
| rd_crc_zero | output | 1 | CRC-zero flag paired with the oldest character |
| overrun | output | 1 | Sticky queue overflow flag |
| hunting | output | 1 | Receiver is in hunt mode |

## Verification
A character becomes visible on `rd_data` in the cycle after the clock edge that carries its eighth strobe. The bench drives each strobe for one cycle starting at a falling edge and reads the outputs at the next falling edge, which lands exactly on that visible cycle. The CRC flag is due two characters after the last byte it covers. The bench's reference model therefore replays the holding register and the before-update sampling point character by character, and it compares each popped flag to the modelled flag rather than looking for the result at the last byte. Hunt, carrier-loss and enable effects take hold on the next edge, and the bench checks them by what does or does not reach the queue afterwards.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int CHAR_W = 8;
  localparam int CRC_W  = 16;
  // x^16+x^15+x^2+1 in bit-reversed form for LSB-first shifting
  localparam logic [CRC_W-1:0] CRC_POLY_LSB = 16'hA001;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_LSB : '0);
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    wrap_inc = (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_stb,
  input  logic             bit_in,
  output logic [IDX_W-1:0] bit_idx,
  output logic             char_done,
  output logic [W-1:0]     char_out
);
  logic [W-1:0] sh_q;

  assign char_out  = {bit_in, sh_q[W-1:1]};
  assign char_done = run & bit_stb & (bit_idx == IDX_W'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_idx <= '0;
    end else if (!run) begin
      sh_q    <= '0;
      bit_idx <= '0;
    end else if (bit_stb) begin
      sh_q    <= char_out;
      bit_idx <= (bit_idx == IDX_W'(W - 1)) ? '0 : bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/crc_delay.sv
module crc_delay
  import sync_rx_pkg::*;
#(
  parameter int W = CHAR_W,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             bit_stb,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             load,
  input  logic [W-1:0]     load_char,
  input  logic             crc_en,
  output logic [CRC_W-1:0] crc_q,
  output logic             crc_zero_now
);
  logic [W-1:0]     hold_q;
  logic             act_q;
  logic             step;
  logic [CRC_W-1:0] crc_d;

  assign step         = run & bit_stb & act_q;
  assign crc_d        = step ? crc_step(crc_q, hold_q[bit_idx]) : crc_q;
  assign crc_zero_now = (crc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= 1'b0;
      crc_q  <= '0;
    end else if (clr) begin
      hold_q <= '0;
      act_q  <= 1'b0;
      crc_q  <= '0;
    end else begin
      crc_q <= crc_d;
      if (load) begin
        hold_q <= load_char;
        act_q  <= crc_en;
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int W     = CHAR_W,
  parameter int DEPTH = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  input  logic             wstat,
  input  logic             pop,
  output logic             valid,
  output logic [W-1:0]     rdata,
  output logic             rstat,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);
  logic [W-1:0]     mem_q  [DEPTH];
  logic             stat_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic             wr_ok, rd_ok, full;

  assign full  = (count == CNT_W'(DEPTH));
  assign valid = (count != '0);
  assign wr_ok = wr & ~full;
  assign rd_ok = pop & valid;
  assign rdata = mem_q[rp_q];
  assign rstat = stat_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count   <= '0;
      overrun <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i]  <= '0;
        stat_q[i] <= 1'b0;
      end
    end else begin
      if (wr & full) overrun <= 1'b1;
      if (wr_ok) begin
        mem_q[wp_q]  <= wdata;
        stat_q[wp_q] <= wstat;
        wp_q         <= PTR_W'(wrap_inc(int'(wp_q), DEPTH));
      end
      if (rd_ok) rp_q <= PTR_W'(wrap_inc(int'(rp_q), DEPTH));
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_dcrc.sv
module sync_rx_dcrc
  import sync_rx_pkg::*;
#(
  parameter int W     = CHAR_W,
  parameter int DEPTH = 3,
  localparam int IDX_W = $clog2(W),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         auto_en,
  input  logic         dcd_n,
  input  logic         hunt_req,
  input  logic         sync_found,
  input  logic         rx_clk_en,
  input  logic         rx_data,
  input  logic         crc_en,
  input  logic         pop,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         rd_crc_zero,
  output logic         overrun,
  output logic         hunting
);
  logic             active;
  logic             run;
  logic             char_done;
  logic [W-1:0]     char_word;
  logic [IDX_W-1:0] bit_idx;
  logic [CRC_W-1:0] crc_q;
  logic             crc_zero_now;
  logic [CNT_W-1:0] fifo_cnt;

  assign active = rx_en & ~(auto_en & dcd_n);
  assign run    = active & ~hunting & ~hunt_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hunting <= 1'b1;
    else if (hunt_req)   hunting <= 1'b1;
    else if (sync_found) hunting <= 1'b0;
  end

  rx_shifter #(.W(W)) shift_i (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_stb(rx_clk_en), .bit_in(rx_data),
    .bit_idx(bit_idx), .char_done(char_done), .char_out(char_word)
  );

  crc_delay #(.W(W)) crc_i (
    .clk(clk), .rst_n(rst_n), .clr(hunt_req), .run(run), .bit_stb(rx_clk_en),
    .bit_idx(bit_idx), .load(char_done), .load_char(char_word), .crc_en(crc_en),
    .crc_q(crc_q), .crc_zero_now(crc_zero_now)
  );

  rx_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .wr(char_done), .wdata(char_word), .wstat(crc_zero_now),
    .pop(pop), .valid(rd_valid), .rdata(rd_data), .rstat(rd_crc_zero),
    .count(fifo_cnt), .overrun(overrun)
  );
endmodule

// File: rtl/sync_rx_dcrc_chk.sv
module sync_rx_dcrc_chk #(
  parameter int DEPTH = 3,
  parameter int IDX_W = 3,
  parameter int CNT_W = 2,
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hunt_req,
  input logic             run,
  input logic             char_done,
  input logic             hunting,
  input logic             overrun,
  input logic             rd_valid,
  input logic             pop,
  input logic [IDX_W-1:0] bit_idx,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic [CRC_W-1:0] crc_q
);
  // R7
  hunt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_req |=> (hunting && crc_q == '0 && bit_idx == '0));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));
  // R2
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !char_done);
  // R8
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> bit_idx == '0);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rd_valid && !char_done) |=> !rd_valid);
endmodule

bind sync_rx_dcrc sync_rx_dcrc_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .CRC_W(sync_rx_pkg::CRC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hunt_req(hunt_req), .run(run), .char_done(char_done),
  .hunting(hunting), .overrun(overrun), .rd_valid(rd_valid), .pop(pop),
  .bit_idx(bit_idx), .fifo_cnt(fifo_cnt), .crc_q(crc_q)
);

// File: tb/sync_rx_dcrc_tb_top.sv
module sync_rx_dcrc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 0, auto_en = 0, dcd_n = 0, hunt_req = 0, sync_found = 0;
  logic rx_clk_en = 0, rx_data = 0, crc_en = 0, pop = 0;
  logic rd_valid, rd_crc_zero, overrun, hunting;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_crc;
  logic [7:0]  m_hold;
  bit          m_act;
  logic [7:0]  mq_d [3];
  bit          mq_s [3];
  int          m_cnt;
  bit          m_ovr;

  always #5 clk = ~clk;

  sync_rx_dcrc dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .auto_en(auto_en), .dcd_n(dcd_n),
    .hunt_req(hunt_req), .sync_found(sync_found), .rx_clk_en(rx_clk_en),
    .rx_data(rx_data), .crc_en(crc_en), .pop(pop), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_crc_zero(rd_crc_zero), .overrun(overrun), .hunting(hunting)
  );

  function automatic logic [15:0] rev16(input logic [15:0] v);
    for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
  endfunction

  // bench CRC: reflected polynomial derived from the normal form 0x8005
  function automatic logic [15:0] ref_bit(input logic [15:0] c, input logic b);
    logic [15:0] p;
    p = rev16(16'h8005);
    if (c[0] != b) ref_bit = (c >> 1) ^ p;
    else           ref_bit = c >> 1;
  endfunction

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = ref_bit(r, d[i]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_crc = '0; m_hold = '0; m_act = 0;
  endtask

  task automatic model_char(input logic [7:0] c, input bit en);
    bit st;
    for (int i = 0; i < 7; i++) if (m_act) m_crc = ref_bit(m_crc, m_hold[i]);
    st = (m_crc == 16'h0);
    if (m_act) m_crc = ref_bit(m_crc, m_hold[7]);
    if (m_cnt < 3) begin
      mq_d[m_cnt] = c; mq_s[m_cnt] = st; m_cnt++;
    end else m_ovr = 1;
    m_hold = c; m_act = en;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_data = b; rx_clk_en = 1;
    @(negedge clk);
    rx_clk_en = 0;
  endtask

  // sends a character; when counted, the model follows it
  task automatic send_char(input logic [7:0] c, input bit en, input bit counted);
    crc_en = en;
    for (int i = 0; i < 8; i++) send_bit(c[i]);
    if (counted) model_char(c, en);
  endtask

  task automatic pulse_hunt();
    @(negedge clk); hunt_req = 1;
    @(negedge clk); hunt_req = 0;
    model_clear();
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_found = 1;
    @(negedge clk); sync_found = 0;
  endtask

  task automatic pop_check(input string req);
    check(rd_valid == (m_cnt > 0), req, rd_valid, (m_cnt > 0));
    if (m_cnt > 0) begin
      check(rd_data == mq_d[0], req, rd_data, mq_d[0]);
      check(rd_crc_zero == mq_s[0], req, rd_crc_zero, mq_s[0]);
      for (int i = 0; i < 2; i++) begin mq_d[i] = mq_d[i+1]; mq_s[i] = mq_s[i+1]; end
      m_cnt--;
    end
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  msg [3];
    logic [15:0] c;
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    model_clear(); m_cnt = 0; m_ovr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2: reset state
    check(hunting == 1, "R2 reset hunting", hunting, 1);
    check(rd_valid == 0, "R1 reset empty", rd_valid, 0);
    check(overrun == 0, "R9 reset overrun", overrun, 0);

    // R2: ignored while hunting, then while disabled
    rx_en = 1;
    send_char(8'h5A, 0, 0);
    check(rd_valid == 0, "R2 hunting ignores bits", rd_valid, 0);
    rx_en = 0;
    pulse_sync();
    check(hunting == 0, "R2 sync exits hunt", hunting, 0);
    send_char(8'hA5, 0, 0);
    check(rd_valid == 0, "R2 disabled ignores bits", rd_valid, 0);
    rx_en = 1;

    // R1 R3 R4 R5: message plus CRC, result two characters later
    msg[0] = 8'h31; msg[1] = 8'h32; msg[2] = 8'h33;
    c = 16'h0;
    for (int i = 0; i < 3; i++) c = ref_byte(c, msg[i]);
    for (int i = 0; i < 3; i++) begin send_char(msg[i], 1, 1); pop_check("R1 message data"); end
    send_char(c[7:0], 1, 1);  pop_check("R3 crc low byte");
    send_char(c[15:8], 1, 1); pop_check("R5 crc high byte");
    send_char(8'h00, 0, 1);   pop_check("R5 first pad");
    send_char(8'hFF, 0, 1);
    check(rd_crc_zero == 1, "R4 zero remainder on second pad", rd_crc_zero, 1);
    check(rd_data == 8'hFF, "R5 pairing character", rd_data, 8'hFF);
    pop_check("R5 second pad");

    // R6: flag stays with its entry while others queue behind it
    send_char(8'h12, 1, 1);
    send_char(8'h34, 1, 1);
    repeat (5) @(negedge clk);
    pop_check("R6 held flag first");
    pop_check("R6 held flag second");

    // R7: hunt clears CRC so statuses read zero afterwards
    pulse_hunt(); pulse_sync();
    for (int i = 0; i < 3; i++) begin
      send_char(8'(i * 37 + 3), 0, 1);
      check(rd_crc_zero == 1, "R7 crc cleared by hunt", rd_crc_zero, 1);
      pop_check("R7 after hunt");
    end

    // R8: carrier loss drops the partial character
    auto_en = 1;
    send_bit(1); send_bit(0); send_bit(1);
    @(negedge clk); dcd_n = 1;
    send_char(8'hC3, 0, 0);
    check(rd_valid == 0, "R8 dcd high blocks", rd_valid, 0);
    @(negedge clk); dcd_n = 0;
    send_char(8'h96, 0, 1);
    check(rd_data == 8'h96, "R8 restart at bit0", rd_data, 8'h96);
    pop_check("R8 after carrier");
    auto_en = 0; dcd_n = 1;
    send_char(8'h69, 0, 1);
    check(rd_data == 8'h69, "R8 dcd ignored without auto", rd_data, 8'h69);
    pop_check("R8 no auto");
    dcd_n = 0;

    // R3 R5: random bytes with random CRC participation
    for (int n = 0; n < 60; n++) begin
      send_char(8'($urandom), 1'($urandom), 1);
      pop_check("R3 random stream");
    end

    // R9 R10: fill, overflow, drain, pop empty
    pulse_hunt(); pulse_sync();
    for (int i = 0; i < 4; i++) send_char(8'(8'hE0 + i), 0, 1);
    check(overrun == 1, "R9 overrun set", overrun, 1);
    for (int i = 0; i < 3; i++) pop_check("R9 oldest three kept");
    check(rd_valid == 0, "R9 fourth dropped", rd_valid, 0);
    pop = 1; @(negedge clk); pop = 0; @(negedge clk);
    check(rd_valid == 0, "R10 pop empty", rd_valid, 0);
    send_char(8'h7E, 0, 1);
    check(rd_data == 8'h7E, "R10 queue intact after empty pop", rd_data, 8'h7E);
    check(overrun == 1, "R9 overrun sticky", overrun, 1);
    pop_check("R10 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule